// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Compare Flags

This block is the data side of a very small accumulator machine. It holds a four-bit accumulator that can be loaded, counted up or counted down, a bank of four general registers, a latch that holds separate read and write register selectors, a three-way comparison flag latch, and the logic that decides whether a conditional segment jump is taken. A microcode sequencer drives it with single-cycle strobes. The sequencer also picks which source feeds the internal data bus.

The bus is fed from a program literal, from an external input port, or from the register chosen by the read selector. A source is enabled through its own active-low enable. When a value is moved into the accumulator, the sequencer keeps the source enabled for three cycles and strobes the load only in the middle cycle. A compare captures less/equal/greater of the accumulator against the bus. A jump strobe for one condition, gated by the matching flag, raises the segment-load strobe, and the accumulator value then goes into the segment register. An output strobe copies the accumulator to an output register.

Top module: `acc_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the flag latch, the register-selector latch and the output register are all cleared to zero.
- R2: The bus carries `lit_data` when `lit_en_n` is low. Otherwise it carries `ext_in` when `in_en_n` is low. Otherwise it carries the selected register when `rd_en_n` is low. Otherwise it carries zero. A low `ld_n` loads the bus value into the accumulator at the clock edge.
- R3: A low `inc_n` adds one to the accumulator, and 4'hF wraps to 4'h0.
- R4: A low `dec_n` subtracts one from the accumulator, and 4'h0 wraps to 4'hF.
- R5: When more than one accumulator strobe is low in a cycle, load wins over increment, and increment wins over decrement.
- R6: A high `sel_le` copies the accumulator into the selector latch. Bits [3:2] give the read register and bits [1:0] give the write register, where codes 0, 1, 2 and 3 pick registers A, B, C and D.
- R7: A low `wr_n` writes the accumulator into the register named by the write selector. The read selector does not affect which register is written.
- R8: A high `flag_le` captures the comparison of the accumulator against the bus into `flags`, with bit 2 for less, bit 1 for equal and bit 0 for greater. Exactly one of the three bits is then set, and the flags keep their value when `flag_le` is low.
- R9: `seg_load` is high in the same cycle when (`jmp_lt` and less) or (`jmp_eq` and equal) or (`jmp_gt` and greater) holds on the latched flags. While it is high, `seg_data` carries the accumulator value.
- R10: A high `out_le` copies the accumulator into `out_q`. Otherwise `out_q` holds its value.
- R11: In a three-cycle source transfer, the accumulator is unchanged after the first cycle and takes the bus value at the end of the middle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lit_data | input | 4 | Program literal nibble |
| ext_in | input | 4 | External input nibble |
| lit_en_n | input | 1 | Put the literal on the bus, active low |
| in_en_n | input | 1 | Put the external input on the bus, active low |
| rd_en_n | input | 1 | Put the selected register on the bus, active low |
| ld_n | input | 1 | Load the accumulator from the bus, active low |
| inc_n | input | 1 | Increment the accumulator, active low |
| dec_n | input | 1 | Decrement the accumulator, active low |
| sel_le | input | 1 | Latch the register selectors from the accumulator |
| wr_n | input | 1 | Write the accumulator to a register, active low |
| flag_le | input | 1 | Latch the comparison flags |
| jmp_lt | input | 1 | Jump-if-less strobe |
| jmp_eq | input | 1 | Jump-if-equal strobe |
| jmp_gt | input | 1 | Jump-if-greater strobe |
| out_le | input | 1 | Latch the accumulator into the output register |
| acc | output | 4 | Accumulator value |
| flags | output | 3 | Latched less, equal, greater |
| seg_load | output | 1 | Segment-register load strobe |
| seg_data | output | 4 | Value for the segment register |
| out_q | output | 4 | Output register |

## Verification
The counting strobes are applied at both wrap points and in conflicting combinations, so the wrap arithmetic can be told apart from the priority order. Registers are written at every write selector while the read selector points elsewhere. Each one is then read back through the bus, and this exposes swapped selector halves or a write that follows the wrong selector. Literal and register compares produce each of less, equal and greater. Every jump strobe is then tried against every flag state, which separates correct gating from crossed conditions. Three-cycle transfers from each bus source, including two sources enabled together, check the timing of the middle-cycle load and the source priority.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmp_flags_t;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_LOAD = 2'd1,
    ACC_UP   = 2'd2,
    ACC_DOWN = 2'd3
  } acc_op_e;
endpackage

// File: rtl/acc_unit.sv
module acc_unit #(
  parameter int unsigned DW = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_n,
  input  logic                   inc_n,
  input  logic                   dec_n,
  input  logic [DW-1:0]          bus,
  output acc_dp_pkg::acc_op_e    op,
  output logic [DW-1:0]          acc_q
);
  import acc_dp_pkg::*;

  function automatic logic [DW-1:0] step_up(input logic [DW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DW-1:0] step_down(input logic [DW-1:0] v);
    return v - 1'b1;
  endfunction

  always_comb begin
    if (!ld_n)       op = ACC_LOAD;
    else if (!inc_n) op = ACC_UP;
    else if (!dec_n) op = ACC_DOWN;
    else             op = ACC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else begin
      unique case (op)
        ACC_LOAD: acc_q <= bus;
        ACC_UP:   acc_q <= step_up(acc_q);
        ACC_DOWN: acc_q <= step_down(acc_q);
        default:  acc_q <= acc_q;
      endcase
    end
  end

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> acc_q == $past(bus));
  // R3
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_n && !inc_n && acc_q == {DW{1'b1}}) |=> acc_q == '0);
  // R4
  dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_n && inc_n && !dec_n && acc_q == '0) |=> acc_q == {DW{1'b1}});
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_n && inc_n && dec_n) |=> $stable(acc_q));
endmodule

// File: rtl/acc_regbank.sv
module acc_regbank #(
  parameter int unsigned DW   = 4,
  parameter int unsigned NREG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] acc,
  input  logic          sel_le,
  input  logic          wr_n,
  output logic [DW-1:0] rdata
);
  localparam int unsigned AW = $clog2(NREG);

  logic [2*AW-1:0] sel_q;
  logic [AW-1:0]   rd_idx;
  logic [AW-1:0]   wr_idx;
  logic [DW-1:0]   bank [NREG];

  assign rd_idx = sel_q[2*AW-1:AW];
  assign wr_idx = sel_q[AW-1:0];
  assign rdata  = bank[rd_idx];

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_le) sel_q <= acc[2*AW-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst && !wr_n && wr_idx == AW'(g)) bank[g] <= acc;
    end
  end

  // R7
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> bank[$past(wr_idx)] == $past(acc));
  // R6
  sel_take_chk: assert property (@(posedge clk) disable iff (rst)
    sel_le |=> {rd_idx, wr_idx} == $past(acc[2*AW-1:0]));
endmodule

// File: rtl/acc_cmp_jump.sv
module acc_cmp_jump #(
  parameter int unsigned DW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DW-1:0]           acc,
  input  logic [DW-1:0]           bus,
  input  logic                    flag_le,
  input  logic                    jmp_lt,
  input  logic                    jmp_eq,
  input  logic                    jmp_gt,
  output acc_dp_pkg::cmp_flags_t  flags_q,
  output logic                    seg_load
);
  import acc_dp_pkg::*;

  function automatic cmp_flags_t compare3(input logic [DW-1:0] a, input logic [DW-1:0] b);
    cmp_flags_t f;
    f.lt = a < b;
    f.eq = a == b;
    f.gt = a > b;
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          flags_q <= '0;
    else if (flag_le) flags_q <= compare3(acc, bus);
  end

  assign seg_load = (jmp_lt & flags_q.lt) | (jmp_eq & flags_q.eq) | (jmp_gt & flags_q.gt);

  // R8
  flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    flag_le |=> $countones(flags_q) == 1);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_le |=> $stable(flags_q));
  // R9
  jump_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    seg_load |-> (flags_q != '0 && (jmp_lt || jmp_eq || jmp_gt)));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int unsigned DW   = 4,
  parameter int unsigned NREG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] lit_data,
  input  logic [DW-1:0] ext_in,
  input  logic          lit_en_n,
  input  logic          in_en_n,
  input  logic          rd_en_n,
  input  logic          ld_n,
  input  logic          inc_n,
  input  logic          dec_n,
  input  logic          sel_le,
  input  logic          wr_n,
  input  logic          flag_le,
  input  logic          jmp_lt,
  input  logic          jmp_eq,
  input  logic          jmp_gt,
  input  logic          out_le,
  output logic [DW-1:0] acc,
  output logic [2:0]    flags,
  output logic          seg_load,
  output logic [DW-1:0] seg_data,
  output logic [DW-1:0] out_q
);
  import acc_dp_pkg::*;

  logic [DW-1:0] bus;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] acc_q;
  acc_op_e       acc_op;
  cmp_flags_t    flags_q;

  always_comb begin
    if (!lit_en_n)     bus = lit_data;
    else if (!in_en_n) bus = ext_in;
    else if (!rd_en_n) bus = reg_rdata;
    else               bus = '0;
  end

  acc_unit #(.DW(DW)) u_acc (
    .clk(clk), .rst(rst), .ld_n(ld_n), .inc_n(inc_n), .dec_n(dec_n),
    .bus(bus), .op(acc_op), .acc_q(acc_q)
  );

  acc_regbank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .acc(acc_q), .sel_le(sel_le), .wr_n(wr_n),
    .rdata(reg_rdata)
  );

  acc_cmp_jump #(.DW(DW)) u_cmp (
    .clk(clk), .rst(rst), .acc(acc_q), .bus(bus), .flag_le(flag_le),
    .jmp_lt(jmp_lt), .jmp_eq(jmp_eq), .jmp_gt(jmp_gt),
    .flags_q(flags_q), .seg_load(seg_load)
  );

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (out_le) out_q <= acc_q;
  end

  assign acc      = acc_q;
  assign flags    = flags_q;
  assign seg_data = acc_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0 && flags == '0 && out_q == '0));
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_le |=> $stable(out_q));
  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_n && (!inc_n || !dec_n)) |-> acc_op == ACC_LOAD);
endmodule

// File: tb/acc_datapath_bench.sv
module acc_datapath_bench;
  logic clk = 0;
  logic rst;
  logic [3:0] lit_data, ext_in;
  logic lit_en_n, in_en_n, rd_en_n, ld_n, inc_n, dec_n, sel_le, wr_n;
  logic flag_le, jmp_lt, jmp_eq, jmp_gt, out_le;
  logic [3:0] acc, seg_data, out_q;
  logic [2:0] flags;
  logic seg_load;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int m_acc, m_flags, m_sel, m_out;
  int m_reg [4];
  string tag;

  always #2 clk = ~clk;

  acc_datapath u_acc_datapath (
    .clk(clk), .rst(rst), .lit_data(lit_data), .ext_in(ext_in),
    .lit_en_n(lit_en_n), .in_en_n(in_en_n), .rd_en_n(rd_en_n),
    .ld_n(ld_n), .inc_n(inc_n), .dec_n(dec_n), .sel_le(sel_le), .wr_n(wr_n),
    .flag_le(flag_le), .jmp_lt(jmp_lt), .jmp_eq(jmp_eq), .jmp_gt(jmp_gt),
    .out_le(out_le), .acc(acc), .flags(flags), .seg_load(seg_load),
    .seg_data(seg_data), .out_q(out_q)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; lit_en_n = 1; in_en_n = 1; rd_en_n = 1; ld_n = 1; inc_n = 1; dec_n = 1;
    sel_le = 0; wr_n = 1; flag_le = 0; jmp_lt = 0; jmp_eq = 0; jmp_gt = 0; out_le = 0;
  endtask

  function automatic int bus_ref();
    if (!lit_en_n) return lit_data;
    if (!in_en_n)  return ext_in;
    if (!rd_en_n)  return m_reg[(m_sel / 4) % 4];
    return 0;
  endfunction

  // one clock: check the same-cycle jump output, advance model, check registers
  task automatic tick();
    int b, na, nf, exp_jump;
    #1;
    exp_jump = ((jmp_lt && m_flags == 4) || (jmp_eq && m_flags == 2) ||
                (jmp_gt && m_flags == 1)) ? 1 : 0;
    check("seg_load (R9)", seg_load, exp_jump);
    if (exp_jump == 1) check("seg_data (R9)", seg_data, m_acc);
    b = bus_ref();
    na = m_acc; nf = m_flags;
    if (!ld_n) na = b;
    else if (!inc_n) na = (m_acc + 1) % 16;
    else if (!dec_n) na = (m_acc + 15) % 16;
    if (flag_le) nf = (m_acc < b) ? 4 : (m_acc == b) ? 2 : 1;
    @(posedge clk);
    if (!rst && !wr_n) m_reg[m_sel % 4] = m_acc;
    if (sel_le) m_sel = m_acc;
    if (out_le) m_out = m_acc;
    m_acc = na; m_flags = nf;
    if (rst) begin m_acc = 0; m_flags = 0; m_sel = 0; m_out = 0; end
    @(negedge clk);
    check("acc", acc, m_acc);
    check("flags", flags, m_flags);
    check("out_q", out_q, m_out);
    idle();
  endtask

  // three-cycle transfer with the load in the middle cycle (R11)
  task automatic xfer(int src, int v);
    for (int c = 0; c < 3; c++) begin
      if (src == 0) begin lit_en_n = 0; lit_data = 4'(v); end
      else if (src == 1) begin in_en_n = 0; ext_in = 4'(v); end
      else rd_en_n = 0;
      ld_n = (c == 1) ? 0 : 1;
      tick();
    end
  endtask

  task automatic load_lit(int v);
    tag = "R2 R11 literal transfer"; xfer(0, v);
  endtask

  initial begin
    idle();
    lit_data = 0; ext_in = 0;
    m_acc = 0; m_flags = 0; m_sel = 0; m_out = 0;
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    rst = 1;
    @(negedge clk);
    rst = 1; tag = "R1 reset"; tick();
    check("R1 acc after reset", acc, 0);
    check("R1 flags after reset", flags, 0);

    // R11 first cycle leaves the accumulator alone
    tag = "R11 first cycle";
    lit_en_n = 0; lit_data = 4'hE; tick();
    check("R11 acc unchanged after first cycle", acc, 0);
    lit_en_n = 0; lit_data = 4'hE; ld_n = 0; tag = "R11 middle"; tick();
    check("R11 acc after middle cycle", acc, 4'hE);
    lit_en_n = 0; lit_data = 4'hE; tag = "R11 last"; tick();

    tag = "R3 increment"; inc_n = 0; tick(); inc_n = 0; tick();
    check("R3 wrap F to 0", acc, 0);
    tag = "R4 decrement"; dec_n = 0; tick();
    check("R4 wrap 0 to F", acc, 4'hF);
    tag = "R5 load over inc"; lit_en_n = 0; lit_data = 4'h5; ld_n = 0; inc_n = 0; dec_n = 0; tick();
    tag = "R5 inc over dec"; inc_n = 0; dec_n = 0; tick();
    check("R5 inc wins", acc, 4'h6);

    // R6 R7 fill each register; read selector points away from the write one
    for (int w = 0; w < 4; w++) begin
      load_lit((((w + 1) % 4) << 2) | w);
      tag = "R6 select"; sel_le = 1; tick();
      load_lit(4'h9 + w);
      tag = "R7 write"; wr_n = 0; tick();
    end
    for (int r = 0; r < 4; r++) begin
      load_lit(r << 2);
      tag = "R6 select read"; sel_le = 1; tick();
      tag = "R2 R6 register transfer"; xfer(2, 0);
      check("R7 register readback", acc, 4'h9 + r);
    end

    tag = "R2 input transfer"; xfer(1, 4'h3);
    tag = "R2 literal beats input";
    lit_en_n = 0; in_en_n = 0; lit_data = 4'hA; ext_in = 4'h4; ld_n = 0; tick();
    check("R2 literal priority", acc, 4'hA);

    // R8 R9 compare and jump gating
    for (int k = 0; k < 3; k++) begin
      int lv;
      lv = (k == 0) ? 4'hC : (k == 1) ? 4'hA : 4'h2;
      tag = "R8 literal compare";
      lit_en_n = 0; lit_data = 4'(lv); flag_le = 1; tick();
      for (int j = 0; j < 3; j++) begin
        tag = "R9 jump gating";
        jmp_lt = (j == 0); jmp_eq = (j == 1); jmp_gt = (j == 2); tick();
      end
      tag = "R8 flags hold"; lit_en_n = 0; lit_data = 4'h0; tick();
    end
    tag = "R8 register compare"; load_lit(0); sel_le = 1; tick();
    rd_en_n = 0; flag_le = 1; tick();
    check("R8 acc 0 below reg A", flags, 3'b100);

    tag = "R10 output"; load_lit(4'h7); out_le = 1; tick();
    check("R10 out latched", out_q, 4'h7);
    tag = "R10 output hold"; inc_n = 0; tick();
    check("R10 out held", out_q, 4'h7);

    tag = "R1 mid reset"; rst = 1; tick();
    check("R1 out cleared", out_q, 0);
    tag = "R1 selector cleared"; load_lit(4'h6); wr_n = 0; tick();
    tag = "R1 readback reg A"; xfer(2, 0);
    check("R1 selector zero reads A", acc, 4'h6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule